// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block picks the fastest DMA transfer mode that both one attached drive and its host controller can use. It takes the drive's identify capability words, the host's per-class capability masks, an optional replacement Ultra mask from a host-side filter, the cable type, the media type and a requested upper limit. It returns a single 8-bit mode code, or zero when DMA must not be used.

A request is taken with a one-cycle `start` pulse while the block is idle. The block captures every input at that edge and then visits the three transfer classes, one per cycle, from fastest to slowest. It stops at the first class that is not above the request and that has a usable mode. `done` pulses for one cycle with the result on `mode_out`, and `mode_out` holds that result until the next request finishes. Mode codes are 0x40 plus n for Ultra mode n, 0x20 plus n for multiword mode n and 0x10 plus n for single-word mode n.

Top module: `dma_mode_sel`

## Requirements
- R1: `start` is taken only while `busy` is low. A `start` seen while `busy` is high is ignored and produces no extra result. Each request yields exactly one one-cycle `done` pulse. `mode_out` keeps its value between pulses.
- R2: When `non_disk` and `host_no_atapi_dma` are both 1, the result is 0x00 whatever the capability inputs. Either flag alone has no effect.
- R3: Classes are tried in the order Ultra, multiword, single-word. The first class that is not skipped and has a nonzero mask decides the result.
- R4: A class is skipped when `req_mode` is below its base code (Ultra 0x40, multiword 0x20, single-word 0x10).
- R5: The Ultra class is usable only when bit 2 of `field_valid` is 1. Its mask is `udma_word[7:0]` ANDed with `filt_udma_mask` when `filt_sel` is 1, or with `host_udma_mask` when `filt_sel` is 0.
- R6: When `req_mode` is above 0x42, `cable_80w` is 0 and the Ultra mask has any of bits 3 to 6 set, that mask is cut to bits 0 to 2.
- R7: The multiword class is usable only when bit 1 of `field_valid` is 1. Its mask is `mwdma_word[7:0] & host_mwdma_mask`.
- R8: When bit 1 of `field_valid` is 1, the single-word mask is `swdma_word[7:0] & host_swdma_mask`. Otherwise a `legacy_sw_mode` of 1 gives the mask 0x03 and a value of 2 gives 0x07, each ANDed with `host_swdma_mask`. A value of 0 or above 2 gives an empty mask.
- R9: The result is the deciding class's base plus the index of the highest set mask bit, limited to at most `req_mode`. It is 0x00 when no class decides.
- R10: Every nonzero result has exactly one of bits 7 to 4 set, which marks its class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; captures all inputs when idle |
| field_valid | input | 16 | Identify word; bit 1 marks the multiword/single-word words valid, bit 2 the Ultra word |
| udma_word | input | 16 | Drive Ultra DMA support bits (low byte used) |
| mwdma_word | input | 16 | Drive multiword DMA support bits (low byte used) |
| swdma_word | input | 16 | Drive single-word DMA support bits (low byte used) |
| legacy_sw_mode | input | 8 | Legacy single-word mode number |
| host_udma_mask | input | 8 | Host Ultra capability mask |
| host_mwdma_mask | input | 8 | Host multiword capability mask |
| host_swdma_mask | input | 8 | Host single-word capability mask |
| filt_sel | input | 1 | Use `filt_udma_mask` in place of `host_udma_mask` |
| filt_udma_mask | input | 8 | Filtered Ultra mask from host logic |
| non_disk | input | 1 | Drive is not a disk |
| host_no_atapi_dma | input | 1 | Host forbids DMA for non-disk drives |
| cable_80w | input | 1 | 80-wire cable present |
| req_mode | input | 8 | Highest mode code allowed |
| busy | output | 1 | Class scan in progress |
| done | output | 1 | One-cycle pulse: result valid |
| mode_out | output | 8 | Selected mode code, 0x00 for none |

## Verification
A wrong class index in the scan shows up on the port within three cycles of `start`. Either the mode code carries the wrong class nibble, or `done` comes one cycle early or late against the number of classes passed over. A cable cut, mask select or legacy conversion that uses the wrong bit shows as a result off by whole mode steps in the very next `done`. For that reason each directed case pairs a request that triggers the rule with a neighbour that does not. A capture register that wrongly reloads during a scan shows as a changed result or as an extra `done` after a `start` arrives while `busy` is high.

// File: rtl/dms_pkg.sv
package dms_pkg;
   localparam int MODE_W = 8;
   localparam int NCLS   = 3;

   localparam logic [MODE_W-1:0] UDMA_BASE  = 8'h40;
   localparam logic [MODE_W-1:0] MWDMA_BASE = 8'h20;
   localparam logic [MODE_W-1:0] SWDMA_BASE = 8'h10;

   // class index order is the scan priority
   typedef enum logic [1:0] {
      CLS_UDMA  = 2'd0,
      CLS_MWDMA = 2'd1,
      CLS_SWDMA = 2'd2
   } cls_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SCAN = 1'b1
   } st_e;

   function automatic logic [MODE_W-1:0] class_base(input int c);
      case (c)
         0:       class_base = UDMA_BASE;
         1:       class_base = MWDMA_BASE;
         default: class_base = SWDMA_BASE;
      endcase
   endfunction
endpackage

// File: rtl/dms_udma_mask.sv
module dms_udma_mask
   import dms_pkg::*;
#(
   parameter int ID_W   = 16,
   parameter int MASK_W = 8
) (
   input  logic              fv_ultra,
   input  logic [ID_W-1:0]   drive_word,
   input  logic [MASK_W-1:0] host_mask,
   input  logic              filt_sel,
   input  logic [MASK_W-1:0] filt_mask,
   input  logic              cable_80w,
   input  logic [MODE_W-1:0] req_mode,
   output logic [MASK_W-1:0] mask
);
   localparam logic [MODE_W-1:0] CLAMP_ABOVE = UDMA_BASE + 8'd2;
   localparam logic [MASK_W-1:0] LOW3 = MASK_W'(7);

   logic [MASK_W-1:0] src;
   logic [MASK_W-1:0] raw;
   logic              cut;

   generate
      if (ID_W > MASK_W) begin : g_spare
         logic unused_hi;
         assign unused_hi = ^drive_word[ID_W-1:MASK_W];
      end
   endgenerate

   always_comb begin
      src  = filt_sel ? filt_mask : host_mask;
      raw  = src & drive_word[MASK_W-1:0];
      cut  = (req_mode > CLAMP_ABOVE) && (|raw[6:3]) && !cable_80w;
      mask = '0;
      if (fv_ultra)
         mask = cut ? (raw & LOW3) : raw;
   end

   // fast modes never survive a short cable once the request exceeds mode 2
   always_comb begin
      if (fv_ultra && !cable_80w && (req_mode > CLAMP_ABOVE) && (mask != '0))
         assert_clamp_R6: assert (mask[6:3] == 4'b0000);
   end
endmodule

// File: rtl/dms_dma_mask.sv
module dms_dma_mask #(
   parameter int ID_W       = 16,
   parameter int MASK_W     = 8,
   parameter bit HAS_LEGACY = 1'b0
) (
   input  logic              fv_dma,
   input  logic [ID_W-1:0]   drive_word,
   input  logic [MASK_W-1:0] host_mask,
   input  logic [7:0]        legacy_mode,
   output logic [MASK_W-1:0] mask
);
   logic [MASK_W-1:0] word_mask;

   assign word_mask = drive_word[MASK_W-1:0] & host_mask;

   generate
      if (ID_W > MASK_W) begin : g_spare
         logic unused_hi;
         assign unused_hi = ^drive_word[ID_W-1:MASK_W];
      end

      if (HAS_LEGACY) begin : g_legacy
         logic [MASK_W-1:0] conv;
         always_comb begin
            case (legacy_mode)
               8'd1:    conv = MASK_W'(3);
               8'd2:    conv = MASK_W'(7);
               default: conv = '0;
            endcase
            mask = fv_dma ? word_mask : (conv & host_mask);
         end
      end else begin : g_plain
         logic unused_legacy;
         assign unused_legacy = ^legacy_mode;
         assign mask = fv_dma ? word_mask : '0;
      end
   endgenerate
endmodule

// File: rtl/dms_msb_index.sv
module dms_msb_index #(
   parameter int W = 8,
   localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      any = |vec;
      for (int i = 0; i < W; i++)
         if (vec[i]) idx = IDX_W'(i);
   end
endmodule

// File: rtl/dms_ctrl.sv
module dms_ctrl
   import dms_pkg::*;
#(
   localparam int SEL_W = $clog2(NCLS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         blocked,
   input  logic [NCLS-1:0]              cls_ok,
   input  logic [NCLS-1:0][MODE_W-1:0]  cls_cand,
   output logic                         load,
   output logic                         busy,
   output logic                         done,
   output logic [MODE_W-1:0]            mode_out
);
   localparam logic [SEL_W-1:0] LAST = SEL_W'(NCLS - 1);

   st_e             st;
   logic [SEL_W-1:0] sel;

   assign load = (st == ST_IDLE) && start;
   assign busy = (st == ST_SCAN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         sel      <= '0;
         done     <= 1'b0;
         mode_out <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  sel <= '0;
                  if (blocked) begin
                     mode_out <= '0;
                     done     <= 1'b1;
                  end else begin
                     st <= ST_SCAN;
                  end
               end
            end
            ST_SCAN: begin
               if (cls_ok[sel]) begin
                  mode_out <= cls_cand[sel];
                  done     <= 1'b1;
                  st       <= ST_IDLE;
               end else if (sel == LAST) begin
                  mode_out <= '0;
                  done     <= 1'b1;
                  st       <= ST_IDLE;
               end else begin
                  sel <= sel + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_sel_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (sel <= LAST));
endmodule

// File: rtl/dma_mode_sel.sv
module dma_mode_sel
   import dms_pkg::*;
#(
   parameter int ID_W   = 16,
   parameter int MASK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ID_W-1:0]   field_valid,
   input  logic [ID_W-1:0]   udma_word,
   input  logic [ID_W-1:0]   mwdma_word,
   input  logic [ID_W-1:0]   swdma_word,
   input  logic [7:0]        legacy_sw_mode,
   input  logic [MASK_W-1:0] host_udma_mask,
   input  logic [MASK_W-1:0] host_mwdma_mask,
   input  logic [MASK_W-1:0] host_swdma_mask,
   input  logic              filt_sel,
   input  logic [MASK_W-1:0] filt_udma_mask,
   input  logic              non_disk,
   input  logic              host_no_atapi_dma,
   input  logic              cable_80w,
   input  logic [7:0]        req_mode,
   output logic              busy,
   output logic              done,
   output logic [7:0]        mode_out
);
   localparam int IDX_W = $clog2(MASK_W);

   generate
      if (MASK_W < 7 || MASK_W > 16 || ID_W < MASK_W) begin : g_bad_cfg
         $error("dma_mode_sel: MASK_W must be 7..16 and no wider than ID_W");
      end
   endgenerate

   // request capture
   logic [2:1]        fv_q;
   logic [ID_W-1:0]   uw_q, mw_q, sw_q;
   logic [7:0]        leg_q;
   logic [MASK_W-1:0] hu_q, hm_q, hs_q, fm_q;
   logic              fsel_q, c80_q, blk_q;
   logic [7:0]        req_q;
   logic              load;
   logic              blocked;
   logic              unused_fv;

   assign blocked   = non_disk && host_no_atapi_dma;
   assign unused_fv = field_valid[0] ^ (^field_valid[ID_W-1:3]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fv_q   <= '0;
         uw_q   <= '0;
         mw_q   <= '0;
         sw_q   <= '0;
         leg_q  <= '0;
         hu_q   <= '0;
         hm_q   <= '0;
         hs_q   <= '0;
         fm_q   <= '0;
         fsel_q <= 1'b0;
         c80_q  <= 1'b0;
         blk_q  <= 1'b0;
         req_q  <= '0;
      end else if (load) begin
         fv_q   <= field_valid[2:1];
         uw_q   <= udma_word;
         mw_q   <= mwdma_word;
         sw_q   <= swdma_word;
         leg_q  <= legacy_sw_mode;
         hu_q   <= host_udma_mask;
         hm_q   <= host_mwdma_mask;
         hs_q   <= host_swdma_mask;
         fm_q   <= filt_udma_mask;
         fsel_q <= filt_sel;
         c80_q  <= cable_80w;
         blk_q  <= blocked;
         req_q  <= req_mode;
      end
   end

   // per-class masks
   logic [NCLS-1:0][MASK_W-1:0] cls_mask;

   dms_udma_mask #(.ID_W(ID_W), .MASK_W(MASK_W)) u_umask (
      .fv_ultra   (fv_q[2]),
      .drive_word (uw_q),
      .host_mask  (hu_q),
      .filt_sel   (fsel_q),
      .filt_mask  (fm_q),
      .cable_80w  (c80_q),
      .req_mode   (req_q),
      .mask       (cls_mask[CLS_UDMA])
   );

   dms_dma_mask #(.ID_W(ID_W), .MASK_W(MASK_W), .HAS_LEGACY(1'b0)) u_mwmask (
      .fv_dma      (fv_q[1]),
      .drive_word  (mw_q),
      .host_mask   (hm_q),
      .legacy_mode (leg_q),
      .mask        (cls_mask[CLS_MWDMA])
   );

   dms_dma_mask #(.ID_W(ID_W), .MASK_W(MASK_W), .HAS_LEGACY(1'b1)) u_swmask (
      .fv_dma      (fv_q[1]),
      .drive_word  (sw_q),
      .host_mask   (hs_q),
      .legacy_mode (leg_q),
      .mask        (cls_mask[CLS_SWDMA])
   );

   // per-class candidate codes
   logic [NCLS-1:0]             cls_ok;
   logic [NCLS-1:0][MODE_W-1:0] cls_cand;

   generate
      for (genvar c = 0; c < NCLS; c++) begin : g_cls
         localparam logic [MODE_W-1:0] BASE = class_base(c);
         logic [IDX_W-1:0]  top_idx;
         logic              has_bit;
         logic [MODE_W-1:0] full;

         dms_msb_index #(.W(MASK_W)) u_msb (
            .vec (cls_mask[c]),
            .idx (top_idx),
            .any (has_bit)
         );

         assign full        = BASE + MODE_W'(top_idx);
         assign cls_ok[c]   = has_bit && (req_q >= BASE);
         assign cls_cand[c] = (full < req_q) ? full : req_q;
      end
   endgenerate

   dms_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .blocked  (blocked),
      .cls_ok   (cls_ok),
      .cls_cand (cls_cand),
      .load     (load),
      .busy     (busy),
      .done     (done),
      .mode_out (mode_out)
   );

   assert_busy_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(req_q));

   assert_blocked_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && blk_q) |-> (mode_out == 8'h00));

   assert_le_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (mode_out <= req_q));

   assert_class_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_out != 8'h00) |-> $onehot(mode_out[7:4]));
endmodule

// File: tb/tb_dma_mode_sel.sv
module tb_dma_mode_sel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] field_valid, udma_word, mwdma_word, swdma_word;
   logic [7:0]  legacy_sw_mode, host_udma_mask, host_mwdma_mask, host_swdma_mask;
   logic        filt_sel;
   logic [7:0]  filt_udma_mask;
   logic        non_disk, host_no_atapi_dma, cable_80w;
   logic [7:0]  req_mode;
   logic        busy, done;
   logic [7:0]  mode_out;

   int errors = 0;
   int checks = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   dma_mode_sel dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .field_valid(field_valid), .udma_word(udma_word),
      .mwdma_word(mwdma_word), .swdma_word(swdma_word),
      .legacy_sw_mode(legacy_sw_mode),
      .host_udma_mask(host_udma_mask), .host_mwdma_mask(host_mwdma_mask),
      .host_swdma_mask(host_swdma_mask), .filt_sel(filt_sel),
      .filt_udma_mask(filt_udma_mask), .non_disk(non_disk),
      .host_no_atapi_dma(host_no_atapi_dma), .cable_80w(cable_80w),
      .req_mode(req_mode), .busy(busy), .done(done), .mode_out(mode_out)
   );

   task automatic check(input bit ok, input string req, input logic [7:0] act,
                        input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // monitor: compares each result pulse with the next expected item
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R1 unexpected done", mode_out, 8'h00);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(mode_out === e, t, mode_out, e);
         end
      end
   end

   task automatic defaults();
      field_valid = 16'h0006; udma_word = 16'h003F; mwdma_word = 16'h0007;
      swdma_word = 16'h0007; legacy_sw_mode = 8'd0;
      host_udma_mask = 8'h7F; host_mwdma_mask = 8'h07; host_swdma_mask = 8'h07;
      filt_sel = 1'b0; filt_udma_mask = 8'h00; non_disk = 1'b0;
      host_no_atapi_dma = 1'b0; cable_80w = 1'b1; req_mode = 8'h46;
   endtask

   task automatic go(input logic [7:0] exp, input string tag);
      @(negedge clk);
      start = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=00 expected=01");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      defaults();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && mode_out == 8'h00, "R1 reset state",
            {6'b0, busy, done} | mode_out, 8'h00);

      // R3 R9 R10: Ultra wins, highest bit 5
      defaults(); go(8'h45, "R3 ultra first");
      repeat (4) @(negedge clk);
      check(mode_out == 8'h45, "R1 hold between results", mode_out, 8'h45);
      defaults(); req_mode = 8'h43; go(8'h43, "R9 limited by request");
      // R6 cut on short cable
      defaults(); cable_80w = 1'b0; go(8'h42, "R6 cut to mode 2");
      defaults(); cable_80w = 1'b0; udma_word = 16'h0038; go(8'h22, "R6 cut empties ultra");
      defaults(); cable_80w = 1'b0; udma_word = 16'h0038; req_mode = 8'h42;
      go(8'h42, "R6 no cut at request 0x42");
      // R4 skip
      defaults(); mwdma_word = 16'h0003; req_mode = 8'h22; go(8'h21, "R4 ultra skipped");
      defaults(); req_mode = 8'h0F; go(8'h00, "R4 all skipped");
      // R5
      defaults(); field_valid = 16'h0002; go(8'h22, "R5 ultra word invalid");
      defaults(); filt_sel = 1'b1; filt_udma_mask = 8'h03; go(8'h41, "R5 filtered mask");
      defaults(); host_udma_mask = 8'h0F; go(8'h43, "R5 host mask");
      // R7 R9: nothing usable
      defaults(); field_valid = 16'h0004; udma_word = 16'h0000; go(8'h00, "R7 R9 no class");
      // R8 legacy conversion
      defaults(); field_valid = 16'h0000; legacy_sw_mode = 8'd2; go(8'h12, "R8 legacy 2");
      defaults(); field_valid = 16'h0000; legacy_sw_mode = 8'd1; go(8'h11, "R8 legacy 1");
      defaults(); field_valid = 16'h0000; legacy_sw_mode = 8'd3; go(8'h00, "R8 legacy 3");
      defaults(); field_valid = 16'h0000; legacy_sw_mode = 8'd2; host_swdma_mask = 8'h01;
      go(8'h10, "R8 legacy host mask");
      defaults(); field_valid = 16'h0002; mwdma_word = 16'h0000; swdma_word = 16'h0002;
      legacy_sw_mode = 8'd2; go(8'h11, "R8 R10 word path");
      // R2
      defaults(); non_disk = 1'b1; host_no_atapi_dma = 1'b1; go(8'h00, "R2 blocked");
      defaults(); non_disk = 1'b1; go(8'h45, "R2 non-disk allowed");
      defaults(); host_no_atapi_dma = 1'b1; go(8'h45, "R2 disk allowed");

      // R1: start during a scan is ignored
      defaults(); field_valid = 16'h0000; legacy_sw_mode = 8'd2;
      @(negedge clk);
      start = 1'b1;
      exp_q.push_back(8'h12);
      tag_q.push_back("R1 first request kept");
      @(negedge clk);
      check(busy == 1'b1, "R1 busy during scan", {7'b0, busy}, 8'h01);
      defaults();
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
      repeat (6) @(negedge clk);
      check(mode_out == 8'h12, "R1 ignored start left result", mode_out, 8'h12);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule